// File: doc/BRIEF.md
# GF(2^131) Digit-Serial Multiplier and Squarer

This block computes products in the binary field GF(2)[z]/(z^131 + z^13 + z^2 + z + 1), with each element held as 131 polynomial-basis coefficients (bit i is the coefficient of z^i). In multiply mode it scans the second operand one digit at a time, starting with the most significant digit. For each digit it shifts an accumulator left and XORs in a multiple of the first operand, which it looks up in a table of digit multiples. It then reduces the double-width product with two fold passes that exploit the sparse reduction polynomial.

In square mode the multiplier array is skipped. The input bits are spread apart with zeros between them, giving a 261-bit square, and that value goes straight into the same two fold passes. A caller presents operands and the mode with a one-cycle `start`. It then waits for the one-cycle `done` pulse, during which `result` carries the reduced answer.

The controller is a five-state machine:
- `S_IDLE` waits for `start`.
- `S_MUL` runs one digit step per cycle.
- `S_FOLD1` performs the first fold.
- `S_FOLD2` performs the second fold and captures the result.
- `S_DONE` raises `done`.

Transitions:
- IDLE→MUL is taken on `start` with `sq_mode`=0.
- IDLE→FOLD1 is taken on `start` with `sq_mode`=1.
- MUL→MUL is taken while digits remain.
- MUL→FOLD1 is taken after the last digit.
- FOLD1→FOLD2, FOLD2→DONE and DONE→IDLE are unconditional.

Top module: `gf131_mul`

## Requirements
- R1: After reset, and before any operation, `done` is 0 and `result` is all zeros.
- R2: With `sq_mode`=0, `result` equals op_a·op_b reduced modulo z^131+z^13+z^2+z+1, where bit i of every vector is the coefficient of z^i.
- R3: Reduction is complete for every product. This includes cases where folding the bits of degree ≥131 once still leaves bits at degree ≥131, for example all-ones times all-ones and z^130·z^130.
- R4: With `sq_mode`=1, `result` equals op_a² reduced modulo the same polynomial. `op_b` has no effect in this mode.
- R5: The operands 0 and 1 behave as field zero and identity: x·0 = 0 and x·1 = 1·x = x.
- R6: In multiply mode, `done` is high in the cycle after the (NDIG+2)-th rising edge following the edge that accepted `start`. Here NDIG = ceil(131/DIGIT_W), so this is 35 edges for DIGIT_W=4.
- R7: In square mode, `done` is high in the cycle after the 2nd rising edge following the accepting edge.
- R8: `done` is high for exactly one cycle per accepted operation, and `result` holds the answer in that cycle.
- R9: A `start` seen while an operation is in progress (any state other than idle) is ignored. It changes neither the result nor the timing of the current operation, and it never causes a later `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept operands and mode when idle |
| sq_mode | input | 1 | 1 = square op_a, 0 = multiply op_a by op_b |
| op_a | input | 131 | First operand, bit i = coefficient of z^i |
| op_b | input | 131 | Second operand (unused when squaring) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 131 | Reduced field result, valid while done is high |

## Verification
The bench builds the block with its default DIGIT_W of 4, which gives 33 digit cycles per multiply. At that setting a sweep of z^i·z^130 and z^i squared over all 131 positions is affordable. That sweep drives every first-fold overflow case and every bit of the fold taps. Fixed operands (0, 1, all-ones) and a batch of pseudo-random pairs are compared against a bit-serial shift-and-reduce model, while cycle counts from `start` to `done` confirm both mode latencies.

// File: rtl/gf131_pkg.sv
package gf131_pkg;
    localparam int FIELD_W = 131;
    localparam int PROD_W  = 2 * FIELD_W - 1;
    localparam int HI_W    = PROD_W - FIELD_W;
    localparam int TOP_TAP = 13;
    localparam int FOLD_W  = HI_W + TOP_TAP;
    localparam int N_TAPS  = 4;
    localparam int TAP_POS [N_TAPS] = '{0, 1, 2, TOP_TAP};

    typedef enum logic [2:0] {
        S_IDLE,
        S_MUL,
        S_FOLD1,
        S_FOLD2,
        S_DONE
    } gf_state_t;
endpackage

// File: rtl/gf131_spread.sv
module gf131_spread
    import gf131_pkg::*;
(
    input  logic [FIELD_W-1:0] val_i,
    output logic [PROD_W-1:0]  sq_o
);
    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        assign sq_o[2*i] = val_i[i];
        if (i < FIELD_W - 1) begin : g_gap
            assign sq_o[2*i+1] = 1'b0;
        end
    end
endmodule

// File: rtl/gf131_fold.sv
module gf131_fold
    import gf131_pkg::*;
(
    input  logic [PROD_W-1:0] val_i,
    output logic [FOLD_W-1:0] val_o
);
    logic [FOLD_W-1:0] hi_ext;

    always_comb begin
        hi_ext             = '0;
        hi_ext[HI_W-1:0]   = val_i[PROD_W-1:FIELD_W];
        val_o              = '0;
        val_o[FIELD_W-1:0] = val_i[FIELD_W-1:0];
        for (int k = 0; k < N_TAPS; k++) begin
            val_o = val_o ^ (hi_ext << TAP_POS[k]);
        end
    end
endmodule

// File: rtl/gf131_digit_mac.sv
module gf131_digit_mac
    import gf131_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic [PROD_W-1:0]  acc_i,
    input  logic [FIELD_W-1:0] a_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [PROD_W-1:0]  acc_o
);
    localparam int N_ENT = 1 << DIGIT_W;
    localparam int ENT_W = FIELD_W + DIGIT_W - 1;

    logic [ENT_W-1:0]  a_ext;
    logic [ENT_W-1:0]  mult_tbl [N_ENT];
    logic [PROD_W-1:0] sel_ext;

    always_comb begin
        a_ext              = '0;
        a_ext[FIELD_W-1:0] = a_i;
        for (int e = 0; e < N_ENT; e++) begin
            mult_tbl[e] = '0;
            for (int j = 0; j < DIGIT_W; j++) begin
                if (((e >> j) & 1) != 0) begin
                    mult_tbl[e] = mult_tbl[e] ^ (a_ext << j);
                end
            end
        end
    end

    always_comb begin
        sel_ext            = '0;
        sel_ext[ENT_W-1:0] = mult_tbl[digit_i];
        acc_o              = (acc_i << DIGIT_W) ^ sel_ext;
    end
endmodule

// File: rtl/gf131_mul.sv
module gf131_mul
    import gf131_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               sq_mode,
    input  logic [FIELD_W-1:0] op_a,
    input  logic [FIELD_W-1:0] op_b,
    output logic               done,
    output logic [FIELD_W-1:0] result
);
    localparam int NDIG  = (FIELD_W + DIGIT_W - 1) / DIGIT_W;
    localparam int PAD_W = NDIG * DIGIT_W;
    localparam int CNT_W = $clog2(NDIG);

    gf_state_t          state_q, state_d;
    logic [FIELD_W-1:0] a_q;
    logic [PAD_W-1:0]   b_q, b_ext;
    logic [CNT_W-1:0]   cnt_q;
    logic [PROD_W-1:0]  acc_q, mac_out, sq_spread, fold_ext;
    logic [FOLD_W-1:0]  fold_out;
    logic [FIELD_W-1:0] res_q;
    logic [DIGIT_W-1:0] cur_digit;

    always_comb begin
        b_ext              = '0;
        b_ext[FIELD_W-1:0] = op_b;
        cur_digit          = b_q[int'(cnt_q)*DIGIT_W +: DIGIT_W];
        fold_ext           = '0;
        fold_ext[FOLD_W-1:0] = fold_out;
    end

    gf131_digit_mac #(.DIGIT_W(DIGIT_W)) i_mac (
        .acc_i   (acc_q),
        .a_i     (a_q),
        .digit_i (cur_digit),
        .acc_o   (mac_out)
    );

    gf131_spread i_spread (
        .val_i (op_a),
        .sq_o  (sq_spread)
    );

    gf131_fold i_fold (
        .val_i (acc_q),
        .val_o (fold_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = sq_mode ? S_FOLD1 : S_MUL;
            S_MUL:   if (cnt_q == '0) state_d = S_FOLD1;
            S_FOLD1: state_d = S_FOLD2;
            S_FOLD2: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            cnt_q <= '0;
            acc_q <= '0;
            res_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        a_q   <= op_a;
                        b_q   <= b_ext;
                        cnt_q <= CNT_W'(NDIG - 1);
                        acc_q <= sq_mode ? sq_spread : '0;
                    end
                end
                S_MUL: begin
                    acc_q <= mac_out;
                    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                end
                S_FOLD1: acc_q <= fold_ext;
                S_FOLD2: res_q <= fold_out[FIELD_W-1:0];
                S_DONE:  ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done   = (state_q == S_DONE);
        result = res_q;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_HOLDS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(a_q) && $stable(b_q)); // R9
    AST_SECOND_FOLD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FOLD2) |-> (fold_out[FOLD_W-1:FIELD_W] == '0)); // R3
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MUL) |-> (cnt_q < CNT_W'(NDIG))); // R6
    AST_RESULT_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> $stable(result)); // R8
endmodule

// File: tb/test_gf131_mul.sv
module test_gf131_mul;
    localparam int FW       = 131;
    localparam int DW       = 4;
    localparam int NDIG     = (FW + DW - 1) / DW;
    localparam int LAT_MUL  = NDIG + 2 + 1;
    localparam int LAT_SQ   = 2 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sq_mode = 1'b0;
    logic [FW-1:0] op_a = '0;
    logic [FW-1:0] op_b = '0;
    logic          done;
    logic [FW-1:0] result;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gf131_mul #(.DIGIT_W(DW)) i_gf131_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .sq_mode(sq_mode),
        .op_a(op_a), .op_b(op_b), .done(done), .result(result)
    );

    function automatic logic [FW-1:0] ref_mul(input logic [FW-1:0] a, input logic [FW-1:0] b);
        logic [FW:0] r;
        r = '0;
        for (int i = FW - 1; i >= 0; i--) begin
            r = r << 1;
            if (r[FW]) r = r ^ ((132'b1 << 131) | (132'b1 << 13) | 132'h7);
            if (b[i]) r = r ^ {1'b0, a};
        end
        return r[FW-1:0];
    endfunction

    function automatic logic [FW-1:0] rnd();
        logic [159:0] w;
        w = {$urandom, $urandom, $urandom, $urandom, $urandom};
        return w[FW-1:0];
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // run one operation; optionally pulse a stray start mid-operation
    task automatic run_op(input string req, input logic sq, input logic [FW-1:0] a,
                          input logic [FW-1:0] b, input bit stray);
        int cyc;
        logic [FW-1:0] exp;
        exp = sq ? ref_mul(a, a) : ref_mul(a, b);
        @(negedge clk);
        op_a = a; op_b = b; sq_mode = sq; start = 1'b1;
        cyc = 0;
        while (cyc < 100) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (stray && cyc == 2) begin
                start = 1'b1; op_a = ~a; op_b = ~b; sq_mode = ~sq;
            end
            if (done) break;
        end
        start = 1'b0;
        check_int({req, " latency"}, cyc, sq ? LAT_SQ : LAT_MUL);
        check_vec(req, result, exp);
        @(negedge clk);
        check_bit({req, " R8 single pulse"}, done, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [FW-1:0] ones, x;
        ones = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 done after reset", done, 1'b0);
        check_vec("R1 result after reset", result, '0);

        x = rnd();
        run_op("R5 x*0", 1'b0, x, '0, 1'b0);
        run_op("R5 x*1", 1'b0, x, 131'd1, 1'b0);
        run_op("R5 1*x", 1'b0, 131'd1, x, 1'b0);
        run_op("R3 ones*ones", 1'b0, ones, ones, 1'b0);
        run_op("R3 z130*z130", 1'b0, 131'b1 << 130, 131'b1 << 130, 1'b0);
        run_op("R4 ones^2", 1'b1, ones, '0, 1'b0);
        run_op("R4 square ignores op_b", 1'b1, x, ones, 1'b0);
        run_op("R4 zero^2", 1'b1, '0, ones, 1'b0);

        for (int i = 0; i < FW; i++) begin
            run_op("R3 z^i*z^130", 1'b0, 131'b1 << i, 131'b1 << 130, 1'b0);
            run_op("R7 z^i squared", 1'b1, 131'b1 << i, '0, 1'b0);
        end

        for (int k = 0; k < 40; k++) begin
            run_op("R2 random mul", 1'b0, rnd(), rnd(), 1'b0);
            run_op("R4 random sq", 1'b1, rnd(), rnd(), 1'b0);
        end

        // R9: stray start while busy, then no extra done
        run_op("R9 stray start mul", 1'b0, rnd(), rnd(), 1'b1);
        run_op("R9 stray start sq", 1'b1, rnd(), rnd(), 1'b1);
        begin
            int extra;
            extra = 0;
            repeat (50) begin
                @(negedge clk);
                if (done) extra++;
            end
            check_int("R9 no done from ignored start", extra, 0);
        end
        run_op("R6 multiply after idle", 1'b0, ones, 131'd3, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule